// File: doc/BRIEF.md
# Oversampling UART Receiver

This block turns a serial receive line into bytes. It runs on the system clock and takes a one-cycle tick from an outside rate generator, at eight or sixteen times the bit rate. The line passes through a two-stage synchronizer. A start edge is then looked for at the programmed polarity. The start bit is confirmed at its middle, and every later bit is sampled at its middle too. Data bits are put together either least-significant first or most-significant first. An optional parity bit is checked, and then the stop bit is checked.

Each received byte goes to the consumer through a single-entry valid/ready output. The byte and `out_valid` stay still until the consumer takes them with `out_ready`. A byte that completes while the entry is still full is lost, and an overrun is recorded. If a pop and a completion fall in the same cycle, the pop frees the entry and the new byte is stored. Four sticky error flags record break, parity, framing and overrun events. A single interrupt line ORs the enabled flags and the enabled receive-available condition, under a global enable. A flow-control output tells the far end whether another byte can be taken.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `out_valid`, all four error flags and `irq` are 0, and `flow_rts` is 1.
- R2: With `cfg_os16`=1, `cfg_start_low`=1 (start bit 0, stop bit 1) and `cfg_lsb_first`=1, a frame of 16 ticks per bit is recovered. The frame holds a start bit, eight data bits sent least-significant first and one stop bit. The byte then appears on `out_data` with `out_valid`=1.
- R3: With `cfg_os16`=0, frames of 8 ticks per bit are recovered correctly.
- R4: With `cfg_start_low`=0, the start bit is 1, the stop bit is 0 and the idle line is 0. Data bits are taken at the line level in both polarities.
- R5: With `cfg_lsb_first`=0, the first data bit received becomes bit 7 of `out_data`.
- R6: With `cfg_parity_en`=1, one parity bit follows the data. With `cfg_parity_odd`=0, the data bits and the parity bit together must hold an even number of ones; with `cfg_parity_odd`=1, an odd number. A mismatch sets `err_parity`, and the byte is still delivered.
- R7: If the line is back at the idle level at the middle of the start bit, no byte is produced and no flag is set.
- R8: If the stop-bit sample is at the start level while at least one data or parity bit is not, `err_frame` is set and the byte is still delivered.
- R9: If every data bit, the parity bit (when enabled) and the stop bit are all at the start level, `err_break` is set, `err_frame` is not, and no byte is delivered.
- R10: If a byte completes while `out_valid`=1 and `out_ready`=0, `err_overrun` is set, the new byte is discarded and the held byte is kept. If `out_ready`=1 in the completion cycle, the new byte is stored and no overrun is flagged.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R12: The error flags stay set until a one-cycle pulse on `clr_status`.
- R13: `irq` is 1 exactly when `irq_en_all`=1 and at least one of these holds: a set flag with its enable at 1, or `out_valid`=1 with `irq_en_rx`=1.
- R14: With `cfg_flow_en`=1, `flow_rts` is the inverse of `out_valid`. With `cfg_flow_en`=0, `flow_rts` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling tick, one cycle wide |
| rxd | input | 1 | Serial receive line (asynchronous) |
| cfg_os16 | input | 1 | 1: 16 ticks per bit, 0: 8 ticks per bit |
| cfg_start_low | input | 1 | 1: start bit low and stop bit high, 0: inverted |
| cfg_lsb_first | input | 1 | 1: least-significant bit first, 0: most-significant first |
| cfg_parity_en | input | 1 | Expect and check one parity bit |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_flow_en | input | 1 | Drive `flow_rts` from occupancy |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | `out_data` holds an unread byte |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| err_break | output | 1 | Sticky break flag |
| err_parity | output | 1 | Sticky parity flag |
| err_frame | output | 1 | Sticky framing flag |
| err_overrun | output | 1 | Sticky overrun flag |
| clr_status | input | 1 | One-cycle clear of all error flags |
| irq_en_all | input | 1 | Global interrupt enable |
| irq_en_rx | input | 1 | Enable for byte-available |
| irq_en_break | input | 1 | Enable for break flag |
| irq_en_parity | input | 1 | Enable for parity flag |
| irq_en_frame | input | 1 | Enable for framing flag |
| irq_en_overrun | input | 1 | Enable for overrun flag |
| irq | output | 1 | Combined interrupt |
| flow_rts | output | 1 | 1: receiver can accept another byte |

## Verification
A byte can complete in the same cycle that the consumer pops the held byte. Whether the new byte is kept or dropped as an overrun depends on that one cycle. To provoke the collision, the bench first runs a reference frame that starts at a fixed phase of the tick, and counts the cycles until `out_valid` rises. It then repeats the frame at the same phase with a byte already held, and pulses `out_ready` in the completion cycle. The result must be the new byte on the output with no overrun. A second run pulses one cycle later, and there the overrun flag must be set and the output left empty.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  // receive state machine
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HUNT
  } rx_state_e;

  // per-frame error report from the framer
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_err_t;

  // sticky flag slots
  localparam int unsigned ERR_CLASSES = 4;
  localparam int unsigned FLG_BRK = 0;
  localparam int unsigned FLG_PAR = 1;
  localparam int unsigned FLG_FRM = 2;
  localparam int unsigned FLG_OVR = 3;

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/osr_rx_framer.sv
module osr_rx_framer
  import osr_rx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OSR_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              os_full,
  input  logic              start_low,
  input  logic              lsb_first,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output rx_err_t           err
);

  localparam int unsigned CNT_W = $clog2(OSR_MAX);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              par_bad;
  logic              all_start;

  logic              start_lvl;
  logic              at_start;
  logic [CNT_W-1:0]  cnt_last;
  logic [CNT_W-1:0]  half_last;
  logic              bit_end;
  logic              mid_start;
  logic [DATA_W-1:0] next_shreg;
  logic              is_break;

  always_comb begin
    start_lvl  = ~start_low;
    at_start   = (line == start_lvl);
    cnt_last   = os_full ? CNT_W'(OSR_MAX - 1) : CNT_W'(OSR_MAX / 2 - 1);
    half_last  = cnt_last >> 1;
    bit_end    = tick && (cnt == cnt_last);
    mid_start  = tick && (cnt == half_last);
    next_shreg = lsb_first ? {line, shreg[DATA_W-1:1]}
                           : {shreg[DATA_W-2:0], line};
    is_break   = all_start && at_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bad   <= 1'b0;
      all_start <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      err       <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && at_start) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (mid_start) begin
            cnt <= '0;
            if (at_start) begin
              state     <= RX_DATA;
              idx       <= '0;
              par_acc   <= 1'b0;
              par_bad   <= 1'b0;
              all_start <= 1'b1;
            end else begin
              state <= RX_IDLE;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt       <= '0;
            shreg     <= next_shreg;
            par_acc   <= par_acc ^ line;
            all_start <= all_start & at_start;
            if (idx == IDX_W'(DATA_W - 1)) state <= par_en ? RX_PAR : RX_STOP;
            else                           idx   <= idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_end) begin
            cnt       <= '0;
            par_bad   <= ((par_acc ^ line) != par_odd);
            all_start <= all_start & at_start;
            state     <= RX_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt     <= '0;
            done    <= 1'b1;
            data    <= shreg;
            err.brk <= is_break;
            err.frm <= at_start && !all_start;
            err.par <= par_bad && !is_break;
            state   <= at_start ? RX_HUNT : RX_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HUNT: begin
          if (tick && !at_start) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/osr_rx_hold.sv
module osr_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_done,
  input  logic              in_drop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);

  logic accept;
  logic load_ok;

  always_comb begin
    accept  = in_done && !in_drop;
    load_ok = !out_valid || out_ready;
    overrun = accept && !load_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept && load_ok) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/osr_rx_status.sv
module osr_rx_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] en,
  input  logic         en_all,
  input  logic         rx_avail,
  input  logic         en_rx,
  output logic [N-1:0] flags,
  output logic         irq
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr)    flags[g] <= 1'b0;
    end
  end

  assign irq = en_all && ((|(flags & en)) || (en_rx && rx_avail));

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR_MAX     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              cfg_os16,
  input  logic              cfg_start_low,
  input  logic              cfg_lsb_first,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_flow_en,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              err_break,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  input  logic              clr_status,
  input  logic              irq_en_all,
  input  logic              irq_en_rx,
  input  logic              irq_en_break,
  input  logic              irq_en_parity,
  input  logic              irq_en_frame,
  input  logic              irq_en_overrun,
  output logic              irq,
  output logic              flow_rts
);

  logic                   line_s;
  logic                   fr_done;
  logic [DATA_W-1:0]      fr_data;
  rx_err_t                fr_err;
  logic                   fr_brk;
  logic                   ovr;
  logic [ERR_CLASSES-1:0] flag_set;
  logic [ERR_CLASSES-1:0] flag_en;
  logic [ERR_CLASSES-1:0] flags;

  osr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  osr_rx_framer #(.DATA_W(DATA_W), .OSR_MAX(OSR_MAX)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .line      (line_s),
    .os_full   (cfg_os16),
    .start_low (cfg_start_low),
    .lsb_first (cfg_lsb_first),
    .par_en    (cfg_parity_en),
    .par_odd   (cfg_parity_odd),
    .done      (fr_done),
    .data      (fr_data),
    .err       (fr_err)
  );

  assign fr_brk = fr_err.brk;

  osr_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_done   (fr_done),
    .in_drop   (fr_brk),
    .in_data   (fr_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (ovr)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_BRK] = fr_done && fr_err.brk;
    flag_set[FLG_PAR] = fr_done && fr_err.par;
    flag_set[FLG_FRM] = fr_done && fr_err.frm;
    flag_set[FLG_OVR] = ovr;
    flag_en           = '0;
    flag_en[FLG_BRK]  = irq_en_break;
    flag_en[FLG_PAR]  = irq_en_parity;
    flag_en[FLG_FRM]  = irq_en_frame;
    flag_en[FLG_OVR]  = irq_en_overrun;
  end

  osr_rx_status #(.N(ERR_CLASSES)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (flag_set),
    .clr      (clr_status),
    .en       (flag_en),
    .en_all   (irq_en_all),
    .rx_avail (out_valid),
    .en_rx    (irq_en_rx),
    .flags    (flags),
    .irq      (irq)
  );

  assign err_break   = flags[FLG_BRK];
  assign err_parity  = flags[FLG_PAR];
  assign err_frame   = flags[FLG_FRM];
  assign err_overrun = flags[FLG_OVR];
  assign flow_rts    = cfg_flow_en ? !out_valid : 1'b1;

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_flow_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              flow_rts,
  input logic              err_parity,
  input logic              err_overrun,
  input logic              clr_status,
  input logic              irq,
  input logic              irq_en_all,
  input logic              fr_done,
  input logic              fr_brk
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && !fr_brk && out_valid && !out_ready |=> err_overrun);

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && !fr_brk && out_valid && out_ready |=> out_valid);

  assert_break_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && fr_brk && !out_valid |=> !out_valid);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !clr_status |=> err_parity);

  assert_irq_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_all |-> !irq);

  assert_rts_off_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flow_en |-> flow_rts);

  assert_rts_full_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flow_en && out_valid |-> !flow_rts);

endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_flow_en (cfg_flow_en),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .flow_rts    (flow_rts),
  .err_parity  (err_parity),
  .err_overrun (err_overrun),
  .clr_status  (clr_status),
  .irq         (irq),
  .irq_en_all  (irq_en_all),
  .fr_done     (fr_done),
  .fr_brk      (fr_brk)
);

// File: tb/test_osr_uart_rx.sv
`timescale 1ns/1ps
module test_osr_uart_rx;

  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic cfg_os16 = 1'b1, cfg_start_low = 1'b1, cfg_lsb_first = 1'b1;
  logic cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_flow_en = 1'b1;
  logic out_ready = 1'b0, clr_status = 1'b0;
  logic irq_en_all = 1'b0, irq_en_rx = 1'b0, irq_en_break = 1'b0;
  logic irq_en_parity = 1'b0, irq_en_frame = 1'b0, irq_en_overrun = 1'b0;
  logic [7:0] out_data;
  logic out_valid, err_break, err_parity, err_frame, err_overrun, irq, flow_rts;
  logic [1:0] tdiv;
  logic tick;
  int checks = 0;
  int fails = 0;
  int lat = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick = (tdiv == 2'(TDIV - 1));

  osr_uart_rx i_osr_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_os16(cfg_os16), .cfg_start_low(cfg_start_low), .cfg_lsb_first(cfg_lsb_first),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd), .cfg_flow_en(cfg_flow_en),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .err_break(err_break), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .clr_status(clr_status),
    .irq_en_all(irq_en_all), .irq_en_rx(irq_en_rx), .irq_en_break(irq_en_break),
    .irq_en_parity(irq_en_parity), .irq_en_frame(irq_en_frame),
    .irq_en_overrun(irq_en_overrun), .irq(irq), .flow_rts(flow_rts)
  );

  function automatic int bit_clks();
    return (cfg_os16 ? 16 : 8) * TDIV;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic lvl);
    rxd = lvl;
    repeat (bit_clks()) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (tdiv != 2'd0) @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic sl;
    sl = ~cfg_start_low;
    drive_bit(sl);
    for (int i = 0; i < 8; i++) drive_bit(cfg_lsb_first ? b[i] : b[7-i]);
    if (cfg_parity_en) drive_bit((^b) ^ cfg_parity_odd ^ bad_par);
    drive_bit(bad_stop ? sl : ~sl);
    rxd = ~sl;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    align();
    send_body(b, bad_par, bad_stop);
  endtask

  task automatic pop();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 flags", {err_break, err_parity, err_frame, err_overrun}, 0);
    check("R1 irq", irq, 0);
    check("R1 flow_rts", flow_rts, 1);
  endtask

  task automatic t_basic16();
    send(8'hA5, 0, 0);
    check("R2 valid", out_valid, 1);
    check("R2 data", out_data, 8'hA5);
    repeat (100) @(negedge clk);
    check("R11 held valid", out_valid, 1);
    check("R11 held data", out_data, 8'hA5);
    pop();
    check("R11 popped", out_valid, 0);
  endtask

  task automatic t_os8();
    cfg_os16 = 1'b0;
    send(8'h3C, 0, 0);
    check("R3 valid", out_valid, 1);
    check("R3 data", out_data, 8'h3C);
    pop();
    cfg_os16 = 1'b1;
  endtask

  task automatic t_msb();
    cfg_lsb_first = 1'b0;
    send(8'h4D, 0, 0);
    check("R5 data", out_data, 8'h4D);
    pop();
    cfg_lsb_first = 1'b1;
  endtask

  task automatic t_polarity();
    @(negedge clk); cfg_start_low = 1'b0; rxd = 1'b0;
    repeat (3 * bit_clks()) @(negedge clk);
    check("R4 no spurious", out_valid, 0);
    send(8'h96, 0, 0);
    check("R4 valid", out_valid, 1);
    check("R4 data", out_data, 8'h96);
    check("R4 no frame err", err_frame, 0);
    pop();
    @(negedge clk); cfg_start_low = 1'b1; rxd = 1'b1;
    repeat (3 * bit_clks()) @(negedge clk);
    check("R4 restore quiet", out_valid, 0);
  endtask

  task automatic t_parity();
    cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
    send(8'h5A, 0, 0);
    check("R6 even ok data", out_data, 8'h5A);
    check("R6 even ok flag", err_parity, 0);
    pop();
    cfg_parity_odd = 1'b1;
    send(8'h07, 0, 0);
    check("R6 odd ok flag", err_parity, 0);
    pop();
    send(8'hC3, 1, 0);
    check("R6 bad flag", err_parity, 1);
    check("R6 bad delivered", out_data, 8'hC3);
    pop();
    repeat (200) @(negedge clk);
    check("R12 sticky", err_parity, 1);
    cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0;
  endtask

  task automatic t_irq();
    irq_en_parity = 1'b1; irq_en_all = 1'b0;
    @(negedge clk); check("R13 gated", irq, 0);
    irq_en_all = 1'b1;
    @(negedge clk); check("R13 parity irq", irq, 1);
    irq_en_parity = 1'b0;
    @(negedge clk); check("R13 disabled", irq, 0);
    clear();
    check("R12 cleared", {err_break, err_parity, err_frame, err_overrun}, 0);
    irq_en_rx = 1'b1;
    send(8'h21, 0, 0);
    check("R13 rx irq", irq, 1);
    pop();
    @(negedge clk); check("R13 rx irq gone", irq, 0);
    irq_en_rx = 1'b0; irq_en_all = 1'b0;
  endtask

  task automatic t_glitch();
    align();
    rxd = 1'b0;
    repeat (2 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bit_clks()) @(negedge clk);
    check("R7 no byte", out_valid, 0);
    check("R7 no flags", {err_break, err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_frame();
    send(8'h55, 0, 1);
    check("R8 frame flag", err_frame, 1);
    check("R8 not break", err_break, 0);
    check("R8 delivered", out_data, 8'h55);
    pop();
    clear();
  endtask

  task automatic t_break();
    align();
    rxd = 1'b0;
    repeat (12 * bit_clks()) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
    check("R9 break flag", err_break, 1);
    check("R9 no frame flag", err_frame, 0);
    check("R9 no byte", out_valid, 0);
    clear();
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    check("R10 overrun flag", err_overrun, 1);
    check("R10 old kept", out_data, 8'h11);
    pop();
    check("R10 new dropped", out_valid, 0);
    clear();
  endtask

  task automatic t_collide();
    logic [7:0] got;
    align();
    lat = 0;
    fork
      send_body(8'h3E, 0, 0);
      begin
        while (!out_valid) begin @(negedge clk); lat++; end
      end
    join
    pop();
    send(8'h61, 0, 0);
    align();
    fork
      send_body(8'h62, 0, 0);
      begin
        repeat (lat - 1) @(negedge clk);
        got = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    check("R10 same-cycle popped old", got, 8'h61);
    check("R10 same-cycle no overrun", err_overrun, 0);
    check("R10 same-cycle new stored", out_data, 8'h62);
    pop();
    send(8'h71, 0, 0);
    align();
    fork
      send_body(8'h72, 0, 0);
      begin
        repeat (lat) @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    check("R10 late pop overrun", err_overrun, 1);
    check("R10 late pop empty", out_valid, 0);
    clear();
  endtask

  task automatic t_flow();
    cfg_flow_en = 1'b1;
    send(8'h0F, 0, 0);
    check("R14 full rts", flow_rts, 0);
    cfg_flow_en = 1'b0;
    @(negedge clk); check("R14 disabled rts", flow_rts, 1);
    cfg_flow_en = 1'b1;
    pop();
    check("R14 empty rts", flow_rts, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3 * 64) @(negedge clk);
    t_basic16();
    t_os8();
    t_msb();
    t_polarity();
    t_parity();
    t_irq();
    t_glitch();
    t_frame();
    t_break();
    t_overrun();
    t_collide();
    t_flow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule